// File: doc/BRIEF.md
# MAC Forwarding Table Engine

This block holds the MAC forwarding table of a small Ethernet switch and carries out table commands issued by software through a register write port. Each of the table's entries stores a 48-bit MAC address, a per-port membership mask, a priority, a static flag and a valid flag. Software stages an entry image in two 32-bit key registers, then writes a command word. The engine raises a busy flag in its status word while it works. Software polls that flag and then reads the result from the status word and the key registers.

The commands are:
- search by MAC, which returns the matching entry, or the first free one;
- store the staged image at an index;
- wipe one index;
- fetch one index into the key registers;
- strip a set of ports from every entry;
- empty the whole table, which is started from a separate main control register.

The engine also holds a learned-entry counter that software steps up, steps down or zeroes. An ageing interval register drives a periodic tick. The table is keyed by MAC only, so one address under several VLANs shares one entry.

Register write addresses: 0 = key low (MAC bits 31:0), 1 = key high, 2 = command, 3 = main control, 4 = learn counter mode, 5 = ageing interval. Key-high layout (defaults of 5 ports, 2 priority bits): [15:0] MAC bits 47:32, [20:16] port mask, [22:21] priority, [23] static, [24] valid, all other bits zero. Command word: [7:0] argument (entry index, or port mask for the strip command), [16] search, [17] store, [18] wipe entry, [19] fetch, [20] strip ports, [21] wait (accepted, no effect). Status word: [31] busy, [7:0] argument/result field, other bits zero.

Top module: `lk_engine`

## Requirements
- R1: After reset the status word, both key registers, the learn counter, the clear-in-progress flag and the ageing tick are all zero.
- R2: A store command (bit 17) copies the key registers into the entry whose index is the command argument, and busy is high for exactly one cycle.
- R3: A fetch command (bit 19) loads key low and key high from the indexed entry, and the status word reports that index. Setting the wait bit 21 alongside it changes nothing.
- R4: A search (bit 16) compares only the MAC in the key registers against valid entries, from index 0 upward. On a hit at index k it returns k in the status field and the entry's key-high image in key high, with busy lasting k+1 cycles.
- R5: A search miss takes busy for all 32 cycles. It returns the lowest-index invalid entry, or index 0 when every entry is valid. Key high then carries the searched MAC bits 47:32, a port mask of all ones (0x1F), and zero priority, static and valid.
- R6: A wipe-entry command (bit 18) zeroes the indexed entry, including its valid flag.
- R7: A strip-ports command (bit 20) visits all 32 entries, one per cycle. It clears the argument's port bits from every valid entry and invalidates any entry whose mask becomes zero. Invalid entries are left unchanged.
- R8: Writing 1 to bit 0 of main control empties the table. The clear-in-progress flag is high for 32 cycles and then drops by itself.
- R9: Writes to the key, command and main control registers are ignored while busy is high.
- R10: Writing the learn register with mode 1 increments the counter, saturating at 32. Mode 2 decrements it, saturating at 0. Mode 3 zeroes it, and mode 0 leaves it unchanged.
- R11: With an ageing value N other than zero, a one-cycle tick occurs every N*1024*32 cycles, the first one that many cycles after the write. A value of zero stops the ticks.
- R12: When a command word sets several command bits, only the lowest-numbered one runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| cmdStatus | output | 32 | Busy flag and argument/result field |
| keyLoOut | output | 32 | Key low register |
| keyHiOut | output | 32 | Key high register |
| learnCount | output | 6 | Learned-entry counter |
| wipeActive | output | 1 | Table clear in progress |
| ageTick | output | 1 | Ageing period pulse |

## Verification
The hardest case to reach is a search that misses on a completely full table, where the result must fall back to index 0. The stimulus first empties the table and then stores all 32 entries under distinct MACs before it searches for an absent address. A second awkward case is a write that arrives while a long scan is running. The bench starts a 32-cycle miss search and, while busy is still high, writes key low and a store command. It then checks that key low kept its value and that the target entry is still empty.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int ARG_W = 8;

  localparam logic [2:0] REG_KEY_LO = 3'd0;
  localparam logic [2:0] REG_KEY_HI = 3'd1;
  localparam logic [2:0] REG_CMD    = 3'd2;
  localparam logic [2:0] REG_MAIN   = 3'd3;
  localparam logic [2:0] REG_LEARN  = 3'd4;
  localparam logic [2:0] REG_AGE    = 3'd5;

  localparam int BIT_SEARCH = 16;
  localparam int BIT_STORE  = 17;
  localparam int BIT_WIPE   = 18;
  localparam int BIT_FETCH  = 19;
  localparam int BIT_STRIP  = 20;

  localparam logic [1:0] LM_INC  = 2'd1;
  localparam logic [1:0] LM_DEC  = 2'd2;
  localparam logic [1:0] LM_ZERO = 2'd3;

  typedef enum logic [2:0] {
    OP_NONE, OP_SEARCH, OP_STORE, OP_WIPE, OP_FETCH, OP_STRIP, OP_CLRALL
  } lkOp_t;

  typedef struct packed {
    logic             doStore;
    logic             doWipe;
    logic             doFetch;
    logic             searchStep;
    logic             stripStep;
    logic             clrStep;
    logic             lastStep;
    logic [ARG_W-1:0] idx;
  } lkStrobe_t;
endpackage

// File: rtl/lk_ctrl.sv
module lk_ctrl
  import lk_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        hitNow,
  output logic        busy,
  output logic        wipeActive,
  output lkStrobe_t   stb
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  lkOp_t           opQ, newOp;
  logic [IDX_W-1:0] idxQ;
  logic            finish;

  always_comb begin
    newOp = OP_NONE;
    if (wrAddr == REG_CMD) begin
      if      (wrData[BIT_SEARCH]) newOp = OP_SEARCH;
      else if (wrData[BIT_STORE])  newOp = OP_STORE;
      else if (wrData[BIT_WIPE])   newOp = OP_WIPE;
      else if (wrData[BIT_FETCH])  newOp = OP_FETCH;
      else if (wrData[BIT_STRIP])  newOp = OP_STRIP;
    end else if (wrAddr == REG_MAIN && wrData[0]) begin
      newOp = OP_CLRALL;
    end
  end

  always_comb begin
    stb = '0;
    stb.doStore    = (opQ == OP_STORE);
    stb.doWipe     = (opQ == OP_WIPE);
    stb.doFetch    = (opQ == OP_FETCH);
    stb.searchStep = (opQ == OP_SEARCH);
    stb.stripStep  = (opQ == OP_STRIP);
    stb.clrStep    = (opQ == OP_CLRALL);
    stb.lastStep   = (idxQ == LAST);
    stb.idx        = ARG_W'(idxQ);
  end

  always_comb begin
    unique case (opQ)
      OP_STORE, OP_WIPE, OP_FETCH: finish = 1'b1;
      OP_SEARCH:                   finish = hitNow || (idxQ == LAST);
      OP_STRIP, OP_CLRALL:         finish = (idxQ == LAST);
      default:                     finish = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= OP_NONE;
      idxQ <= '0;
    end else if (opQ == OP_NONE) begin
      if (wrEn && newOp != OP_NONE) begin
        opQ  <= newOp;
        idxQ <= '0;
      end
    end else if (finish) begin
      opQ  <= OP_NONE;
      idxQ <= '0;
    end else begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign busy       = (opQ != OP_NONE);
  assign wipeActive = (opQ == OP_CLRALL);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> (opQ == $past(opQ) || opQ == OP_NONE));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));

  // R8
  clr_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wipeActive) |-> $past(stb.lastStep));
endmodule

// File: rtl/lk_data.sv
module lk_data
  import lk_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PORTS   = 5,
  parameter int PRIO_W  = 2,
  parameter int AGE_W   = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [2:0]                     wrAddr,
  input  logic [31:0]                    wrData,
  input  logic                           busy,
  input  lkStrobe_t                      stb,
  output logic                           hitNow,
  output logic [31:0]                    keyLoOut,
  output logic [31:0]                    keyHiOut,
  output logic [ARG_W-1:0]               argField,
  output logic [$clog2(ENTRIES+1)-1:0]   learnCount,
  output logic [AGE_W-1:0]               ageVal,
  output logic                           ageWr
);
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int CNT_W    = $clog2(ENTRIES + 1);
  localparam int MASK_LSB = 16;
  localparam int PRIO_LSB = MASK_LSB + PORTS;
  localparam int STAT_BIT = PRIO_LSB + PRIO_W;
  localparam int VAL_BIT  = STAT_BIT + 1;

  logic [47:0]       tMac  [ENTRIES];
  logic [PORTS-1:0]  tMask [ENTRIES];
  logic [PRIO_W-1:0] tPrio [ENTRIES];
  logic              tStat [ENTRIES];
  logic              tVal  [ENTRIES];

  logic [31:0]       keyLo, keyHi;
  logic              freeSeen, curFreeSeen, nFreeSeen;
  logic [IDX_W-1:0]  freeIdx, nFreeIdx, scanIdx, argIdx;
  logic [31:0]       entHi, missHi;
  logic [PORTS-1:0]  stripMask;
  logic              idle;

  assign scanIdx   = stb.idx[IDX_W-1:0];
  assign argIdx    = argField[IDX_W-1:0];
  assign stripMask = argField[PORTS-1:0];
  assign idle      = !busy;
  assign hitNow    = tVal[scanIdx] && (tMac[scanIdx] == {keyHi[15:0], keyLo});

  function automatic logic [31:0] packHi(logic [15:0] macHi, logic [PORTS-1:0] m,
                                         logic [PRIO_W-1:0] p, logic s, logic v);
    logic [31:0] h;
    h = '0;
    h[15:0]             = macHi;
    h[MASK_LSB+:PORTS]  = m;
    h[PRIO_LSB+:PRIO_W] = p;
    h[STAT_BIT]         = s;
    h[VAL_BIT]          = v;
    return h;
  endfunction

  always_comb begin
    entHi  = packHi(tMac[stb.doFetch ? argIdx : scanIdx][47:32],
                    tMask[stb.doFetch ? argIdx : scanIdx],
                    tPrio[stb.doFetch ? argIdx : scanIdx],
                    tStat[stb.doFetch ? argIdx : scanIdx],
                    tVal[stb.doFetch ? argIdx : scanIdx]);
    missHi = packHi(keyHi[15:0], '1, '0, 1'b0, 1'b0);
    curFreeSeen = (scanIdx == '0) ? 1'b0 : freeSeen;
    nFreeSeen   = curFreeSeen;
    nFreeIdx    = freeIdx;
    if (!curFreeSeen && !tVal[scanIdx]) begin
      nFreeSeen = 1'b1;
      nFreeIdx  = scanIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tMac[i] <= '0; tMask[i] <= '0; tPrio[i] <= '0; tStat[i] <= 1'b0; tVal[i] <= 1'b0;
      end
      keyLo <= '0; keyHi <= '0; argField <= '0;
      freeSeen <= 1'b0; freeIdx <= '0;
    end else begin
      if (idle && wrEn) begin
        if (wrAddr == REG_KEY_LO) keyLo <= wrData;
        if (wrAddr == REG_KEY_HI) keyHi <= wrData;
        if (wrAddr == REG_CMD)    argField <= wrData[ARG_W-1:0];
      end
      if (stb.doStore) begin
        tMac[argIdx]  <= {keyHi[15:0], keyLo};
        tMask[argIdx] <= keyHi[MASK_LSB+:PORTS];
        tPrio[argIdx] <= keyHi[PRIO_LSB+:PRIO_W];
        tStat[argIdx] <= keyHi[STAT_BIT];
        tVal[argIdx]  <= keyHi[VAL_BIT];
      end
      if (stb.doWipe) begin
        tMac[argIdx] <= '0; tMask[argIdx] <= '0; tPrio[argIdx] <= '0;
        tStat[argIdx] <= 1'b0; tVal[argIdx] <= 1'b0;
      end
      if (stb.clrStep) begin
        tMac[scanIdx] <= '0; tMask[scanIdx] <= '0; tPrio[scanIdx] <= '0;
        tStat[scanIdx] <= 1'b0; tVal[scanIdx] <= 1'b0;
      end
      if (stb.doFetch) begin
        keyLo <= tMac[argIdx][31:0];
        keyHi <= entHi;
      end
      if (stb.stripStep && tVal[scanIdx]) begin
        tMask[scanIdx] <= tMask[scanIdx] & ~stripMask;
        if ((tMask[scanIdx] & ~stripMask) == '0) tVal[scanIdx] <= 1'b0;
      end
      if (stb.searchStep) begin
        freeSeen <= nFreeSeen;
        freeIdx  <= nFreeIdx;
        if (hitNow) begin
          keyHi    <= entHi;
          argField <= ARG_W'(scanIdx);
        end else if (stb.lastStep) begin
          keyHi    <= missHi;
          argField <= nFreeSeen ? ARG_W'(nFreeIdx) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      learnCount <= '0;
      ageVal     <= '0;
    end else if (wrEn) begin
      if (wrAddr == REG_AGE) ageVal <= wrData[AGE_W-1:0];
      if (wrAddr == REG_LEARN) begin
        unique case (wrData[1:0])
          LM_INC:  if (learnCount < CNT_W'(ENTRIES)) learnCount <= learnCount + 1'b1;
          LM_DEC:  if (learnCount != '0) learnCount <= learnCount - 1'b1;
          LM_ZERO: learnCount <= '0;
          default: ;
        endcase
      end
    end
  end

  assign ageWr    = wrEn && (wrAddr == REG_AGE);
  assign keyLoOut = keyLo;
  assign keyHiOut = keyHi;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    learnCount <= CNT_W'(ENTRIES));

  // R5
  miss_image_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.searchStep && stb.lastStep && !hitNow) |=>
      (keyHi[MASK_LSB+:PORTS] == '1 && !keyHi[VAL_BIT] && !keyHi[STAT_BIT]));

  // R8
  clr_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStep |=> !tVal[$past(scanIdx)]);

  // R6
  wipe_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWipe |=> !tVal[$past(argIdx)]);
endmodule

// File: rtl/lk_age_timer.sv
module lk_age_timer #(
  parameter int ENTRIES   = 32,
  parameter int TICK_UNIT = 1024,
  parameter int AGE_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AGE_W-1:0] ageVal,
  input  logic             ageWr,
  output logic             ageTick
);
  localparam int SUB_LIM = TICK_UNIT * ENTRIES;
  localparam int SUB_W   = $clog2(SUB_LIM);

  logic [SUB_W-1:0] subCnt;
  logic [AGE_W-1:0] unitCnt;

  always_ff @(posedge clk) begin
    if (!rstN || ageWr || ageVal == '0) begin
      subCnt  <= '0;
      unitCnt <= '0;
      ageTick <= 1'b0;
    end else if (subCnt == SUB_W'(SUB_LIM - 1)) begin
      subCnt <= '0;
      if (unitCnt == ageVal - 1'b1) begin
        unitCnt <= '0;
        ageTick <= 1'b1;
      end else begin
        unitCnt <= unitCnt + 1'b1;
        ageTick <= 1'b0;
      end
    end else begin
      subCnt  <= subCnt + 1'b1;
      ageTick <= 1'b0;
    end
  end

  // R11
  tick_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    ageTick |-> (ageVal != '0 && !$past(ageWr)));
endmodule

// File: rtl/lk_engine.sv
module lk_engine
  import lk_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int PORTS     = 5,
  parameter int PRIO_W    = 2,
  parameter int AGE_W     = 16,
  parameter int TICK_UNIT = 1024
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [2:0]                         wrAddr,
  input  logic [31:0]                        wrData,
  output logic [31:0]                        cmdStatus,
  output logic [31:0]                        keyLoOut,
  output logic [31:0]                        keyHiOut,
  output logic [$clog2(ENTRIES+1)-1:0]       learnCount,
  output logic                               wipeActive,
  output logic                               ageTick
);
  lkStrobe_t        stb;
  logic             busy, hitNow, ageWr;
  logic [ARG_W-1:0] argField;
  logic [AGE_W-1:0] ageVal;

  lk_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hitNow(hitNow), .busy(busy), .wipeActive(wipeActive), .stb(stb)
  );

  lk_data #(.ENTRIES(ENTRIES), .PORTS(PORTS), .PRIO_W(PRIO_W), .AGE_W(AGE_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .stb(stb), .hitNow(hitNow), .keyLoOut(keyLoOut), .keyHiOut(keyHiOut),
    .argField(argField), .learnCount(learnCount), .ageVal(ageVal), .ageWr(ageWr)
  );

  lk_age_timer #(.ENTRIES(ENTRIES), .TICK_UNIT(TICK_UNIT), .AGE_W(AGE_W)) uAge (
    .clk(clk), .rstN(rstN), .ageVal(ageVal), .ageWr(ageWr), .ageTick(ageTick)
  );

  assign cmdStatus = {busy, {(31-ARG_W){1'b0}}, argField};
endmodule

// File: tb/tb_lk_engine.sv
module tb_lk_engine;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT_CYC   = 1024 * 32;

  localparam logic [31:0] C_SEARCH = 32'h0001_0000;
  localparam logic [31:0] C_STORE  = 32'h0002_0000;
  localparam logic [31:0] C_WIPE   = 32'h0004_0000;
  localparam logic [31:0] C_FETCH  = 32'h0008_0000;
  localparam logic [31:0] C_STRIP  = 32'h0010_0000;
  localparam logic [31:0] C_WAIT   = 32'h0020_0000;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] cmdStatus, keyLoOut, keyHiOut;
  logic [5:0]  learnCount;
  logic        wipeActive, ageTick;

  lk_engine dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmdStatus(cmdStatus), .keyLoOut(keyLoOut), .keyHiOut(keyHiOut),
    .learnCount(learnCount), .wipeActive(wipeActive), .ageTick(ageTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int sel; logic [31:0] exp; string req; } item_t;
  item_t sbq[$];
  int nChecks = 0, nFails = 0;
  bit  done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return cmdStatus;
      1: return keyLoOut;
      2: return keyHiOut;
      3: return {26'd0, learnCount};
      default: return {31'd0, wipeActive};
    endcase
  endfunction

  task automatic expectQ(int sel, logic [31:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: pops expectations and compares them against the outputs
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.req, pick(it.sel), it.exp);
    end
  end

  function automatic logic [31:0] hiWord(logic [47:0] mac, logic [4:0] m,
                                          logic [1:0] p, logic s, logic v);
    return {7'd0, v, s, p, m, mac[47:32]};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (cmdStatus[31]) begin cyc++; @(negedge clk); end
  endtask

  task automatic cmd(logic [31:0] w, output int cyc);
    wr(3'd2, w);
    waitIdle(cyc);
  endtask

  task automatic putEntry(int idx, logic [47:0] mac, logic [4:0] m, logic [1:0] p,
                          logic s, logic v);
    int c;
    wr(3'd0, mac[31:0]);
    wr(3'd1, hiWord(mac, m, p, s, v));
    cmd(C_STORE | 32'(idx), c);
  endtask

  task automatic searchMac(logic [47:0] mac, logic [15:0] junk, output int cyc);
    wr(3'd0, mac[31:0]);
    wr(3'd1, {junk, mac[47:32]});
    cmd(C_SEARCH, cyc);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finishRun();
  end

  localparam logic [47:0] MAC_A = 48'h0A11_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0B66_7788_99AA;
  localparam logic [47:0] MAC_C = 48'h0CBB_CCDD_EEFF;
  localparam logic [47:0] MAC_D = 48'h0D01_0203_0405;
  localparam logic [47:0] MAC_X = 48'h0E0E_0E0E_0E0E;

  initial begin
    int c;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    expectQ(0, 32'h0, "R1 status"); expectQ(1, 32'h0, "R1 keyLo");
    expectQ(2, 32'h0, "R1 keyHi");  expectQ(3, 32'h0, "R1 learn");
    expectQ(4, 32'h0, "R1 clearing");
    n = 0;
    repeat (500) begin @(negedge clk); if (ageTick) n++; end
    check("R1 R11 no tick at zero age", n, 0);

    // R2 store and single-cycle busy
    wr(3'd0, MAC_A[31:0]); wr(3'd1, hiWord(MAC_A, 5'b00011, 2'd1, 1'b1, 1'b1));
    cmd(C_STORE | 32'd3, c);
    check("R2 store busy cycles", c, 1);
    putEntry(7, MAC_B, 5'b00100, 2'd0, 1'b0, 1'b1);
    putEntry(0, MAC_C, 5'b10000, 2'd2, 1'b0, 1'b1);

    // R3 fetch with wait bit
    cmd(C_FETCH | C_WAIT | 32'd3, c);
    check("R3 fetch busy cycles", c, 1);
    expectQ(1, MAC_A[31:0], "R3 fetch keyLo");
    expectQ(2, hiWord(MAC_A, 5'b00011, 2'd1, 1'b1, 1'b1), "R3 fetch keyHi");
    expectQ(0, 32'd3, "R3 fetch status index");
    settle();

    // R4 search hit at index 3, non-MAC key bits differ
    searchMac(MAC_A, 16'h0160, c);
    check("R4 hit busy cycles", c, 4);
    expectQ(0, 32'd3, "R4 hit index");
    expectQ(2, hiWord(MAC_A, 5'b00011, 2'd1, 1'b1, 1'b1), "R4 hit image");
    settle();
    searchMac(MAC_C, 16'h0000, c);
    check("R4 hit at index 0 cycles", c, 1);
    expectQ(0, 32'd0, "R4 hit index 0");
    settle();

    // R5 miss returns lowest free index
    searchMac(MAC_D, 16'h01FF, c);
    check("R5 miss busy cycles", c, 32);
    expectQ(0, 32'd1, "R5 miss free index");
    expectQ(2, hiWord(MAC_D, 5'h1F, 2'd0, 1'b0, 1'b0), "R5 miss image");
    settle();

    // R12 several command bits: store wins over fetch
    wr(3'd0, MAC_D[31:0]); wr(3'd1, hiWord(MAC_D, 5'b01000, 2'd3, 1'b0, 1'b1));
    cmd(C_STORE | C_FETCH | 32'd9, c);
    check("R12 store-only cycles", c, 1);
    expectQ(1, MAC_D[31:0], "R12 keyLo unchanged by fetch");
    settle();
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    cmd(C_FETCH | 32'd9, c);
    expectQ(2, hiWord(MAC_D, 5'b01000, 2'd3, 1'b0, 1'b1), "R12 entry stored");
    settle();

    // R6 wipe one entry
    cmd(C_WIPE | 32'd7, c);
    cmd(C_FETCH | 32'd7, c);
    expectQ(2, 32'h0, "R6 wiped entry");
    expectQ(1, 32'h0, "R6 wiped entry mac");
    settle();
    searchMac(MAC_B, 16'h0, c);
    check("R6 wiped entry misses", c, 32);
    expectQ(0, 32'd1, "R6 miss index");
    settle();

    // R7 strip ports 0 and 4
    putEntry(12, MAC_X, 5'b11111, 2'd0, 1'b0, 1'b0);
    cmd(C_STRIP | 32'h11, c);
    check("R7 strip busy cycles", c, 32);
    cmd(C_FETCH | 32'd0, c);
    expectQ(2, hiWord(MAC_C, 5'b00000, 2'd2, 1'b0, 1'b0), "R7 emptied entry invalid");
    settle();
    cmd(C_FETCH | 32'd3, c);
    expectQ(2, hiWord(MAC_A, 5'b00010, 2'd1, 1'b1, 1'b1), "R7 partial strip");
    settle();
    cmd(C_FETCH | 32'd12, c);
    expectQ(2, hiWord(MAC_X, 5'b11111, 2'd0, 1'b0, 1'b0), "R7 invalid untouched");
    settle();

    // R9 writes while busy ignored
    wr(3'd0, MAC_B[31:0]); wr(3'd1, {16'h0, MAC_B[47:32]});
    wr(3'd2, C_SEARCH);
    wr(3'd0, 32'hDEAD_BEEF);
    wr(3'd2, C_STORE | 32'd20);
    wr(3'd3, 32'h1);
    check("R9 still busy during writes", cmdStatus[31], 1'b1);
    waitIdle(c);
    expectQ(1, MAC_B[31:0], "R9 keyLo kept");
    expectQ(4, 32'h0, "R9 clear-table not started");
    settle();
    cmd(C_FETCH | 32'd20, c);
    expectQ(2, 32'h0, "R9 store ignored");
    settle();

    // R8 clear whole table
    wr(3'd3, 32'h1);
    n = 0;
    while (wipeActive) begin n++; @(negedge clk); end
    check("R8 clearing cycles", n, 32);
    expectQ(4, 32'h0, "R8 flag self-clears");
    cmd(C_FETCH | 32'd3, c);
    expectQ(2, 32'h0, "R8 entry gone");
    settle();

    // R5 full table miss returns index 0
    for (int i = 0; i < 32; i++) putEntry(i, 48'h0000_1000_0000 + 48'(i), 5'b00001, 2'd0, 1'b0, 1'b1);
    searchMac(MAC_X, 16'h0, c);
    check("R5 full-table miss cycles", c, 32);
    expectQ(0, 32'd0, "R5 full-table index");
    expectQ(2, hiWord(MAC_X, 5'h1F, 2'd0, 1'b0, 1'b0), "R5 full-table image");
    settle();
    searchMac(48'h0000_1000_001F, 16'h0, c);
    check("R4 hit at last index cycles", c, 32);
    expectQ(0, 32'd31, "R4 hit last index");
    settle();

    // R10 learn counter modes
    wr(3'd4, 32'd1); wr(3'd4, 32'd1); wr(3'd4, 32'd1);
    expectQ(3, 32'd3, "R10 increment");
    wr(3'd4, 32'd2);
    expectQ(3, 32'd2, "R10 decrement");
    wr(3'd4, 32'd0);
    expectQ(3, 32'd2, "R10 mode zero no effect");
    wr(3'd4, 32'd3);
    expectQ(3, 32'd0, "R10 set zero");
    wr(3'd4, 32'd2);
    expectQ(3, 32'd0, "R10 decrement saturates");
    for (int i = 0; i < 34; i++) wr(3'd4, 32'd1);
    expectQ(3, 32'd32, "R10 increment saturates");
    settle();

    // R11 ageing tick period
    wr(3'd5, 32'd1);
    n = 0;
    while (!ageTick && n < 3 * UNIT_CYC) begin @(negedge clk); n++; end
    check("R11 first tick delay", n, UNIT_CYC);
    @(negedge clk); n = 1;
    while (!ageTick && n < 3 * UNIT_CYC) begin @(negedge clk); n++; end
    check("R11 tick interval", n, UNIT_CYC);
    wr(3'd5, 32'd0);
    n = 0;
    repeat (2000) begin @(negedge clk); if (ageTick) n++; end
    check("R11 zero disables", n, 0);

    settle();
    finishRun();
  end
endmodule